// File: doc/BRIEF.md
# Error Notification Packet Payload Generator

This block turns a pending error report into an outbound maintenance notification payload for the system host. The error register blocks raise a report request. When the block is idle and no earlier notification is still unacknowledged, it takes a snapshot of four 32-bit status words: the component tag, the port error detect register, the logical/transport error detect register, and the port identifier with implementation-specific bits. It also takes a snapshot of the target device ID. It then streams the 16-byte payload most significant byte first over a valid/ready interface. The beats are `DATA_W` bits wide: 8 bits for a byte-wide stream, 32 bits for a word-wide stream.

When a send begins, the block sets a pending status bit. While that bit is set, further report requests are ignored. Software acknowledges the notification by writing a one to the bit, which the block sees as a single-cycle clear strobe. Forming the packet header beyond the target ID, physical transmission and retry are done elsewhere.

Top module: `errNotifyGen`

## Requirements
- R1: After reset, `outValid` is 0 and `pending` is 0.
- R2: A send begins at a rising edge where the block is idle, `pending` is 0 and `reportReq` is 1. In the next cycle `outValid` is 1 and `pending` is 1.
- R3: The payload is the 128-bit value {compTag, portErrDet, ltErrDet, portIdInfo}. Beat n (counting from 0) carries bits [127-n*DATA_W -: DATA_W] of that value, so bytes go out most significant first.
- R4: The payload words are sampled at the edge where the send begins. Changes to them afterwards do not alter the notification in flight.
- R5: While `outValid` is 1 and `outReady` is 0, `outValid`, `outData`, `outLast` and `outTarget` hold their values. The block moves to the next beat only when a beat is accepted.
- R6: `outLast` is 1 only on beat 128/DATA_W-1. In the cycle after that beat is accepted, `outValid` is 0.
- R7: While `pending` is 1, `reportReq` starts no send, and `outValid` stays 0.
- R8: A one-cycle `pendClr` pulse clears `pending` in the next cycle. After that, a request starts a new send.
- R9: `outTarget` equals the `targetId` sampled when the send began, and it holds that value for the whole transfer.
- R10: Requests raised during a transfer are dropped, not queued. This is true even if `pending` was cleared during the transfer. After the last beat the block stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reportReq | input | 1 | Error report request from the error register blocks |
| compTag | input | 32 | Component tag register contents |
| portErrDet | input | 32 | Port error detect register contents |
| ltErrDet | input | 32 | Logical/transport error detect register contents |
| portIdInfo | input | 32 | Port identifier and implementation-specific bits |
| targetId | input | ID_W | Host device ID for the notification |
| pendClr | input | 1 | Software write-one-to-clear strobe for the pending bit |
| pending | output | 1 | Notification pending status bit |
| outValid | output | 1 | Payload beat valid |
| outReady | input | 1 | Payload beat accepted by the sink |
| outData | output | DATA_W | Payload beat, most significant byte first |
| outLast | output | 1 | Marks the final payload beat |
| outTarget | output | ID_W | Snapshot of the target device ID |

## Verification
A request driven before a rising edge shows up in the next cycle as `outValid` and `pending`. A `pendClr` pulse shows up the same way, one cycle later. The bench drives its inputs and samples the outputs on the falling edge, so every result it checks is one register stage after the edge that caused it. On every beat it compares `outData`, `outLast` and `outTarget` against a slice of the expected 128-bit payload, and it moves to the next slice only after a falling edge where it had driven `outReady` high. This means a stalled beat is checked again against the same expected value. After the last accepted beat, the bench checks one cycle later that the block is idle. It also changes the source words straight after the start edge, and clears `pending` and raises a request in the middle of a transfer, to confirm that neither has any effect at the ports.

// File: rtl/errNotifyPkg.sv
package errNotifyPkg;
  localparam int PAYLOAD_W = 128;

  typedef struct packed {
    logic load;   // capture payload and target
    logic shift;  // advance to next beat
  } ctrlStb_t;
endpackage

// File: rtl/errNotifyCtrl.sv
module errNotifyCtrl
  import errNotifyPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     reportReq,
  input  logic     pendClr,
  input  logic     outReady,
  output logic     pending,
  output logic     outValid,
  output logic     outLast,
  output ctrlStb_t stb
);
  localparam int NUM_BEATS = PAYLOAD_W / DATA_W;
  localparam int CNT_W = (NUM_BEATS > 1) ? $clog2(NUM_BEATS) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NUM_BEATS - 1);

  logic busy;
  logic [CNT_W-1:0] beatCnt;
  logic startSend, accept, atLast;

  assign startSend = !busy && !pending && reportReq;
  assign accept    = busy && outReady;
  assign atLast    = (beatCnt == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      beatCnt <= '0;
    end else if (startSend) begin
      busy    <= 1'b1;
      beatCnt <= '0;
    end else if (accept) begin
      if (atLast) busy <= 1'b0;
      beatCnt <= beatCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          pending <= 1'b0;
    else if (startSend) pending <= 1'b1;
    else if (pendClr)   pending <= 1'b0;
  end

  always_comb begin
    stb.load  = startSend;
    stb.shift = accept;
  end

  assign outValid = busy;
  assign outLast  = busy && atLast;

  p_start_sets_pend_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!outValid && !pending && reportReq) |=> (outValid && pending));

  p_valid_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && ($stable(outLast))));

  p_last_ends_r6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outLast && outReady) |=> !outValid);

  p_pend_blocks_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!outValid && pending) |=> !outValid);

  p_pend_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (pending && pendClr) |=> !pending);
endmodule

// File: rtl/errNotifyDp.sv
module errNotifyDp
  import errNotifyPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ID_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic [31:0]       compTag,
  input  logic [31:0]       portErrDet,
  input  logic [31:0]       ltErrDet,
  input  logic [31:0]       portIdInfo,
  input  logic [ID_W-1:0]   targetId,
  output logic [DATA_W-1:0] outData,
  output logic [ID_W-1:0]   outTarget
);
  logic [PAYLOAD_W-1:0] payload;
  logic [ID_W-1:0]      targetQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      payload <= '0;
      targetQ <= '0;
    end else if (stb.load) begin
      payload <= {compTag, portErrDet, ltErrDet, portIdInfo};
      targetQ <= targetId;
    end else if (stb.shift) begin
      payload <= payload << DATA_W;
    end
  end

  assign outData   = payload[PAYLOAD_W-1 -: DATA_W];
  assign outTarget = targetQ;

  p_load_captures_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> (outData == $past(compTag[31 -: DATA_W])));
endmodule

// File: rtl/errNotifyGen.sv
module errNotifyGen
  import errNotifyPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ID_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reportReq,
  input  logic [31:0]       compTag,
  input  logic [31:0]       portErrDet,
  input  logic [31:0]       ltErrDet,
  input  logic [31:0]       portIdInfo,
  input  logic [ID_W-1:0]   targetId,
  input  logic              pendClr,
  output logic              pending,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] outData,
  output logic              outLast,
  output logic [ID_W-1:0]   outTarget
);
  ctrlStb_t stb;

  generate
    if ((PAYLOAD_W % DATA_W) != 0 || DATA_W < 8 || DATA_W > 32) begin : g_badWidth
      initial $error("errNotifyGen: DATA_W must divide 128 and lie in 8..32");
    end
  endgenerate

  errNotifyCtrl #(.DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .reportReq(reportReq), .pendClr(pendClr),
    .outReady(outReady), .pending(pending), .outValid(outValid),
    .outLast(outLast), .stb(stb)
  );

  errNotifyDp #(.DATA_W(DATA_W), .ID_W(ID_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .compTag(compTag),
    .portErrDet(portErrDet), .ltErrDet(ltErrDet), .portIdInfo(portIdInfo),
    .targetId(targetId), .outData(outData), .outTarget(outTarget)
  );

  p_beat_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> ($stable(outData) && $stable(outTarget)));
endmodule

// File: tb/sim_errNotifyGen.sv
`timescale 1ns/1ps
module sim_errNotifyGen;
  localparam int DATA_W = 32;
  localparam int ID_W   = 16;
  localparam int NB     = 128 / DATA_W;

  logic clk = 1'b0;
  logic rstN, reportReq, pendClr, outReady;
  logic [31:0] compTag, portErrDet, ltErrDet, portIdInfo;
  logic [ID_W-1:0] targetId;
  logic pending, outValid, outLast;
  logic [DATA_W-1:0] outData;
  logic [ID_W-1:0] outTarget;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  errNotifyGen #(.DATA_W(DATA_W), .ID_W(ID_W)) u0 (
    .clk(clk), .rstN(rstN), .reportReq(reportReq), .compTag(compTag),
    .portErrDet(portErrDet), .ltErrDet(ltErrDet), .portIdInfo(portIdInfo),
    .targetId(targetId), .pendClr(pendClr), .pending(pending),
    .outValid(outValid), .outReady(outReady), .outData(outData),
    .outLast(outLast), .outTarget(outTarget)
  );

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] expBeat(logic [127:0] p, int i);
    return p[127 - i*DATA_W -: DATA_W];
  endfunction

  // One notification: start, optional source mutation, optional mid-transfer clear.
  task automatic sendOne(logic [31:0] w0, w1, w2, w3, logic [ID_W-1:0] tgt,
                         int readyPct, bit mutate, bit midClr);
    logic [127:0] exp = {w0, w1, w2, w3};
    int beat = 0;
    int iter = 0;
    compTag = w0; portErrDet = w1; ltErrDet = w2; portIdInfo = w3;
    targetId = tgt; reportReq = 1'b1;
    @(negedge clk);
    reportReq = 1'b0;
    check("R2 valid after start", 128'(outValid), 128'(1));
    check("R2 pending after start", 128'(pending), 128'(1));
    if (mutate) begin // R4: source words change after the start edge
      compTag = $urandom; portErrDet = $urandom; ltErrDet = $urandom;
      portIdInfo = $urandom; targetId = ID_W'($urandom);
    end
    while (beat < NB && iter < 1000) begin
      bit rdy = (($urandom % 100) < readyPct);
      check("R3 beat data", 128'(outData), 128'(expBeat(exp, beat)));
      check("R6 last flag", 128'(outLast), 128'(beat == NB - 1));
      check("R9 target", 128'(outTarget), 128'(tgt));
      check("R5 valid held", 128'(outValid), 128'(1));
      outReady = rdy;
      if (midClr && iter == 1) begin pendClr = 1'b1; reportReq = 1'b1; end
      @(negedge clk);
      pendClr = 1'b0; reportReq = 1'b0;
      if (rdy) beat++;
      iter++;
    end
    outReady = 1'b0;
    check("R6 idle after last", 128'(outValid), 128'(0));
    if (midClr) begin
      check("R10 pending cleared mid-transfer", 128'(pending), 128'(0));
      @(negedge clk);
      check("R10 no queued send", 128'(outValid), 128'(0));
    end else begin
      reportReq = 1'b1; // R7: request while pending
      @(negedge clk);
      reportReq = 1'b0;
      @(negedge clk);
      check("R7 blocked by pending", 128'(outValid), 128'(0));
      pendClr = 1'b1;
      @(negedge clk);
      pendClr = 1'b0;
      check("R8 pending cleared", 128'(pending), 128'(0));
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    rstN = 1'b0; reportReq = 1'b0; pendClr = 1'b0; outReady = 1'b0;
    compTag = '0; portErrDet = '0; ltErrDet = '0; portIdInfo = '0; targetId = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset valid", 128'(outValid), 128'(0));
    check("R1 reset pending", 128'(pending), 128'(0));

    // Directed: always ready, distinct bytes
    sendOne(32'h0102_0304, 32'h1112_1314, 32'h2122_2324, 32'h3132_3334,
            16'hABCD, 100, 0, 0);
    // Directed: heavy stall, all-ones/zeros, mutation
    sendOne(32'hFFFF_FFFF, 32'h0, 32'h8000_0001, 32'hDEAD_BEEF,
            16'hFFFF, 20, 1, 0);
    // Directed: mid-transfer clear and request
    sendOne(32'hCAFE_F00D, 32'h1234_5678, 32'h9ABC_DEF0, 32'h0F0F_0F0F,
            16'h0001, 60, 1, 1);

    for (int k = 0; k < 30; k++) begin
      sendOne($urandom, $urandom, $urandom, $urandom, ID_W'($urandom),
              10 + ($urandom % 91), bit'($urandom % 2), bit'(k % 5 == 4));
    end

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule